// File: doc/BRIEF.md
# Spill Trigger and Readout Sequencer

This block is the fast-control sequencer of a front-end board. During a beam spill it is in step with the bunch clock. It strobes the preamplifier reset and the pipeline clock once per bunch. It stamps each rising discriminator hit with a cycle time and a bunch number, and sends a trigger pulse back to the analog pipeline. The pipeline can hold at most four marked slots, so a spill accepts no more than four triggers.

When the spill ends, the pipeline keeps clocking until a programmed number of bunches has passed. This lets a hit from the last bunch still be marked. The block then reads out each marked slot in turn: one multiplexer reset, then 32 multiplexer clocks. For every clock it takes two 10-bit words from a bus shared by two ADCs, the high-gain word first and the low-gain word second. After the 32nd clock of a slot it releases that slot back to the pipeline.

Each record carries the trigger time, the bunch number, a board identifier, a channel tag and the data. In raw mode every word is sent. In processed mode a per-channel pedestal is subtracted, a negative result becomes zero, and only values above a threshold are kept. Between spills a free-run mode arms on one hit, waits out the latency, reads that one slot and arms again.

Top module: `spillSeq`

## Requirements
- R1: After reset, every control output (preReset, plnClk, skipTrig, muxReset, muxClk, adcSel, moveData), busy and recValid are low.
- R2: While acquiring (in a spill, in free-run, or while draining), each bunchTick produces a one-cycle pulse on plnClk and on preReset one cycle later.
- R3: Each rising edge of discHit while acquiring gives a one-cycle skipTrig pulse one cycle later. At most 4 are accepted per spill, and further hits and hits during readout are ignored.
- R4: After spillOn falls, exactly `latency` more bunchTicks are clocked into the pipeline before readout starts. Hits in that window are still accepted.
- R5: Each triggered slot is read as one muxReset cycle followed by 32 muxClk pulses, with one muxClk every 4 cycles.
- R6: For each multiplexer clock, the high-gain word (adcSel=0) is taken first and the low-gain word (adcSel=1) second. Each word is latched after adcSel has been stable for one cycle. The channel tag is 2*clockIndex + gain, with bit 0 = 1 meaning low gain.
- R7: Every record carries the cycle time and the bunch number (bunchTicks since acquisition start) of its trigger, and boardId. Slots are read in trigger order.
- R8: In raw mode (rawMode=1) each slot gives 64 records whose data is the bus value.
- R9: In processed mode, data = max(adc - pedVal, 0), where pedVal is looked up for the tag shown on pedChan. A word is emitted only if data > threshold.
- R10: moveData pulses for one cycle after the 32nd multiplexer clock of each slot, and before the next slot's muxReset.
- R11: busy rises one cycle after the end of acquisition and stays high until the last record has been emitted. A spill with no trigger raises busy only for the drain.
- R12: With spillOn low and freeRun high, the first accepted hit ends acquisition and exactly one slot is read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| spillOn | input | 1 | High for the duration of a spill |
| freeRun | input | 1 | Between-spill free-run enable |
| bunchTick | input | 1 | One-cycle pulse per bunch |
| discHit | input | 1 | OR of discriminator outputs |
| rawMode | input | 1 | 1 = raw records, 0 = processed |
| latency | input | 8 | Drain length in bunches |
| threshold | input | 10 | Keep threshold for processed mode |
| boardId | input | 8 | Board identifier for records |
| adcBus | input | 10 | Shared ADC data bus |
| pedVal | input | 10 | Pedestal for the channel on pedChan |
| preReset | output | 1 | Preamplifier reset strobe |
| plnClk | output | 1 | Pipeline clock strobe |
| skipTrig | output | 1 | Trigger to pipeline |
| muxReset | output | 1 | Multiplexer reset |
| muxClk | output | 1 | Multiplexer and ADC clock |
| adcSel | output | 1 | Bus select, 0 = high gain |
| moveData | output | 1 | Release of the read slot |
| busy | output | 1 | Drain or readout in progress |
| pedChan | output | 6 | Channel tag for pedestal lookup |
| recValid | output | 1 | Record strobe |
| recTime | output | 16 | Trigger cycle time |
| recBunch | output | 12 | Trigger bunch number |
| recBoard | output | 8 | Board identifier |
| recChan | output | 6 | Channel tag |
| recData | output | 10 | Sample value |

## Verification
The hardest conditions to reach are the edges of the trigger window: a fifth hit inside a spill, a hit that arrives during the drain after spillOn has fallen, and a hit during readout. The stimulus places these hits at known cycles against a bunch tick that repeats every four cycles. It lowers spillOn on a cycle that carries no tick, so the drain count is exact. A bench ADC model follows muxReset and muxClk and makes some words fall below their pedestal, so clamping and zero suppression can be told apart.

// File: rtl/spillSeqPkg.sv
package spillSeqPkg;
  localparam int MAX_TRIG = 4;
  localparam int SAMPLES  = 32;
  localparam int SLOT_W   = $clog2(MAX_TRIG);
  localparam int CNT_W    = $clog2(MAX_TRIG + 1);
  localparam int STEP_W   = $clog2(SAMPLES);
  localparam int CHAN_W   = STEP_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ACQ, S_DRAIN, S_MRST, S_SAMP, S_REL
  } seqState_t;

  typedef struct packed {
    logic              stamp;
    logic [SLOT_W-1:0] wrIdx;
    logic              capture;
    logic              gainLo;
    logic [STEP_W-1:0] step;
    logic [SLOT_W-1:0] slot;
    logic              spillStart;
    logic              tickCount;
  } seqStrobe_t;
endpackage

// File: rtl/spillSeqCtrl.sv
module spillSeqCtrl
  import spillSeqPkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spillOn,
  input  logic             freeRun,
  input  logic             bunchTick,
  input  logic             discHit,
  input  logic [LAT_W-1:0] latency,
  output seqStrobe_t       strobe,
  output logic             plnClk,
  output logic             preReset,
  output logic             skipTrig,
  output logic             muxReset,
  output logic             muxClk,
  output logic             adcSel,
  output logic             moveData,
  output logic             busy
);
  seqState_t         state;
  logic              modeFree, hitPrev;
  logic [CNT_W-1:0]  trigCnt;
  logic [LAT_W-1:0]  latCnt;
  logic [SLOT_W-1:0] slot;
  logic [STEP_W-1:0] step;
  logic [1:0]        ph;
  logic              acquiring, hitAcc;

  assign acquiring = (state == S_ACQ) || (state == S_DRAIN);
  assign hitAcc    = discHit && !hitPrev && acquiring && (trigCnt < CNT_W'(MAX_TRIG));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      modeFree <= 1'b0;
      hitPrev  <= 1'b0;
      trigCnt  <= '0;
      latCnt   <= '0;
      slot     <= '0;
      step     <= '0;
      ph       <= '0;
      skipTrig <= 1'b0;
      plnClk   <= 1'b0;
      preReset <= 1'b0;
    end else begin
      hitPrev  <= discHit;
      skipTrig <= hitAcc;
      plnClk   <= bunchTick && acquiring;
      preReset <= bunchTick && acquiring;
      if (hitAcc) trigCnt <= trigCnt + 1'b1;
      case (state)
        S_IDLE: if (spillOn || freeRun) begin
          state    <= S_ACQ;
          modeFree <= !spillOn;
          trigCnt  <= '0;
        end
        S_ACQ: if (modeFree ? (hitAcc || !freeRun) : !spillOn) begin
          state  <= S_DRAIN;
          latCnt <= '0;
        end
        S_DRAIN: begin
          if (latCnt >= latency) begin
            state <= (trigCnt != '0 || hitAcc) ? S_MRST : S_IDLE;
            slot  <= '0;
          end else if (bunchTick) begin
            latCnt <= latCnt + 1'b1;
          end
        end
        S_MRST: begin
          state <= S_SAMP;
          step  <= '0;
          ph    <= '0;
        end
        S_SAMP: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            if (step == STEP_W'(SAMPLES - 1)) state <= S_REL;
            else step <= step + 1'b1;
          end
        end
        S_REL: begin
          if (CNT_W'(slot) + 1'b1 >= trigCnt) state <= S_IDLE;
          else begin
            slot  <= slot + 1'b1;
            state <= S_MRST;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign muxReset = (state == S_MRST);
  assign muxClk   = (state == S_SAMP) && (ph == 2'd0);
  assign adcSel   = (state == S_SAMP) && ph[1];
  assign moveData = (state == S_REL);
  assign busy     = (state == S_DRAIN) || (state == S_MRST) ||
                    (state == S_SAMP)  || (state == S_REL);

  always_comb begin
    strobe            = '0;
    strobe.stamp      = hitAcc;
    strobe.wrIdx      = trigCnt[SLOT_W-1:0];
    strobe.capture    = (state == S_SAMP) && ph[0];
    strobe.gainLo     = ph[1];
    strobe.step       = step;
    strobe.slot       = slot;
    strobe.spillStart = (state == S_IDLE) && (spillOn || freeRun);
    strobe.tickCount  = bunchTick && acquiring;
  end
endmodule

// File: rtl/spillSeqData.sv
module spillSeqData
  import spillSeqPkg::*;
#(
  parameter int ADC_W   = 10,
  parameter int TIME_W  = 16,
  parameter int BUNCH_W = 12,
  parameter int BOARD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [ADC_W-1:0]   adcBus,
  input  logic [ADC_W-1:0]   pedVal,
  input  logic [ADC_W-1:0]   threshold,
  input  logic               rawMode,
  input  logic [BOARD_W-1:0] boardId,
  output logic               recValid,
  output logic [TIME_W-1:0]  recTime,
  output logic [BUNCH_W-1:0] recBunch,
  output logic [BOARD_W-1:0] recBoard,
  output logic [CHAN_W-1:0]  recChan,
  output logic [ADC_W-1:0]   recData
);
  logic [TIME_W-1:0]  timeCnt;
  logic [BUNCH_W-1:0] bunchNum;
  logic [TIME_W-1:0]  stampTime  [MAX_TRIG];
  logic [BUNCH_W-1:0] stampBunch [MAX_TRIG];
  logic [ADC_W:0]     diff;
  logic [ADC_W-1:0]   corr, value;
  logic               keep;

  assign diff  = {1'b0, adcBus} - {1'b0, pedVal};
  assign corr  = diff[ADC_W] ? '0 : diff[ADC_W-1:0];
  assign keep  = rawMode || (corr > threshold);
  assign value = rawMode ? adcBus : corr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeCnt  <= '0;
      bunchNum <= '0;
      recValid <= 1'b0;
      recTime  <= '0;
      recBunch <= '0;
      recBoard <= '0;
      recChan  <= '0;
      recData  <= '0;
      for (int i = 0; i < MAX_TRIG; i++) begin
        stampTime[i]  <= '0;
        stampBunch[i] <= '0;
      end
    end else begin
      timeCnt <= timeCnt + 1'b1;
      if (strobe.spillStart) bunchNum <= '0;
      else if (strobe.tickCount) bunchNum <= bunchNum + 1'b1;
      if (strobe.stamp) begin
        stampTime[strobe.wrIdx]  <= timeCnt;
        stampBunch[strobe.wrIdx] <= bunchNum;
      end
      recValid <= strobe.capture && keep;
      if (strobe.capture) begin
        recTime  <= stampTime[strobe.slot];
        recBunch <= stampBunch[strobe.slot];
        recBoard <= boardId;
        recChan  <= {strobe.step, strobe.gainLo};
        recData  <= value;
      end
    end
  end
endmodule

// File: rtl/spillSeq.sv
module spillSeq
  import spillSeqPkg::*;
#(
  parameter int ADC_W   = 10,
  parameter int TIME_W  = 16,
  parameter int BUNCH_W = 12,
  parameter int BOARD_W = 8,
  parameter int LAT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               spillOn,
  input  logic               freeRun,
  input  logic               bunchTick,
  input  logic               discHit,
  input  logic               rawMode,
  input  logic [LAT_W-1:0]   latency,
  input  logic [ADC_W-1:0]   threshold,
  input  logic [BOARD_W-1:0] boardId,
  input  logic [ADC_W-1:0]   adcBus,
  input  logic [ADC_W-1:0]   pedVal,
  output logic               preReset,
  output logic               plnClk,
  output logic               skipTrig,
  output logic               muxReset,
  output logic               muxClk,
  output logic               adcSel,
  output logic               moveData,
  output logic               busy,
  output logic [CHAN_W-1:0]  pedChan,
  output logic               recValid,
  output logic [TIME_W-1:0]  recTime,
  output logic [BUNCH_W-1:0] recBunch,
  output logic [BOARD_W-1:0] recBoard,
  output logic [CHAN_W-1:0]  recChan,
  output logic [ADC_W-1:0]   recData
);
  seqStrobe_t strobe;

  spillSeqCtrl #(.LAT_W(LAT_W)) ctrl (
    .clk, .rstN, .spillOn, .freeRun, .bunchTick, .discHit, .latency,
    .strobe, .plnClk, .preReset, .skipTrig, .muxReset, .muxClk, .adcSel,
    .moveData, .busy
  );

  spillSeqData #(.ADC_W(ADC_W), .TIME_W(TIME_W), .BUNCH_W(BUNCH_W), .BOARD_W(BOARD_W)) data (
    .clk, .rstN, .strobe, .adcBus, .pedVal, .threshold, .rawMode, .boardId,
    .recValid, .recTime, .recBunch, .recBoard, .recChan, .recData
  );

  assign pedChan = {strobe.step, strobe.gainLo};
endmodule

// File: rtl/spillSeqChecker.sv
module spillSeqChecker
  import spillSeqPkg::*;
#(
  parameter int ADC_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             skipTrig,
  input logic             adcSel,
  input logic             recValid,
  input logic             muxClk,
  input logic             muxReset,
  input logic             moveData,
  input logic             rawMode,
  input logic             busy,
  input logic [ADC_W-1:0] recData,
  input logic [ADC_W-1:0] threshold
);
  logic [STEP_W:0] muxCnt;

  always_ff @(posedge clk) begin
    if (!rstN) muxCnt <= '0;
    else if (muxReset) muxCnt <= '0;
    else if (muxClk) muxCnt <= muxCnt + 1'b1;
  end

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    skipTrig |=> !skipTrig); // R3
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> ($past(adcSel) == $past(adcSel, 2))); // R6
  AST_REL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    moveData |-> (muxCnt == (STEP_W+1)'(SAMPLES))); // R10
  AST_PROC_THRESH: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !rawMode) |-> (recData > threshold)); // R9
  AST_REC_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> busy); // R11
endmodule

bind spillSeq spillSeqChecker #(.ADC_W(ADC_W)) chk (.*);

// File: tb/spillSeq_test.sv
module spillSeq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spillOn = 0, freeRun = 0, bunchTick = 0, discHit = 0, rawMode = 1;
  logic [7:0] latency = 8'd3;
  logic [9:0] threshold = 10'd0;
  logic [7:0] boardId = 8'hA5;
  logic [9:0] adcBus, pedVal;
  logic preReset, plnClk, skipTrig, muxReset, muxClk, adcSel, moveData, busy;
  logic [5:0] pedChan, recChan;
  logic recValid;
  logic [15:0] recTime;
  logic [11:0] recBunch;
  logic [7:0] recBoard;
  logic [9:0] recData;

  always #2.5 clk = ~clk;

  spillSeq uut (
    .clk, .rstN, .spillOn, .freeRun, .bunchTick, .discHit, .rawMode, .latency,
    .threshold, .boardId, .adcBus, .pedVal, .preReset, .plnClk, .skipTrig,
    .muxReset, .muxClk, .adcSel, .moveData, .busy, .pedChan, .recValid,
    .recTime, .recBunch, .recBoard, .recChan, .recData
  );

  int nChk = 0, nFail = 0;
  int tbCyc = 0, tbBunch = 0;
  bit tickEn = 0;
  int mSlot = -1, mStep = -1, nextC = 0, slotClk = 0;
  int nPln = 0, nPre = 0, drainPln = 0, nTrig = 0, nMrst = 0, nMclk = 0, nRel = 0, nRec = 0;
  bit inDrain = 0, seenBusy = 0;
  int hitT[4], hitB[4];
  int nHit = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int adcVal(int s, int k, bit g);
    if (k < 0 || s < 0) return 0;
    return (s * 97 + k * 29 + (g ? 311 : 3)) % 1024;
  endfunction
  function automatic int pedOf(int c);
    return (c * 37) % 512;
  endfunction
  function automatic int procVal(int s, int c);
    int d = adcVal(s, c / 2, c[0]) - pedOf(c);
    return (d < 0) ? 0 : d;
  endfunction
  function automatic bit keepF(int s, int c);
    return rawMode || (procVal(s, c) > int'(threshold));
  endfunction
  function automatic int expData(int s, int c);
    return rawMode ? adcVal(s, c / 2, c[0]) : procVal(s, c);
  endfunction
  function automatic int expRecs(int slots);
    int n = 0;
    for (int s = 0; s < slots; s++)
      for (int c = 0; c < 64; c++)
        if (keepF(s, c)) n++;
    return n;
  endfunction

  assign adcBus = 10'(adcVal(mSlot, mStep, adcSel));
  assign pedVal = 10'(pedOf(int'(pedChan)));

  always @(posedge clk) begin
    if (!rstN) tbCyc <= 0;
    else tbCyc <= tbCyc + 1;
  end

  always @(posedge clk) begin
    #2;
    if (tickEn && (tbCyc % 4 == 0)) begin
      bunchTick = 1;
      tbBunch++;
    end else bunchTick = 0;
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) seenBusy = 1;
      if (plnClk) nPln++;
      if (preReset) nPre++;
      if (inDrain && plnClk) drainPln++;
      if (skipTrig) nTrig++;
      if (muxReset) begin
        inDrain = 0; nMrst++; mSlot++; mStep = -1; nextC = 0; slotClk = 0;
      end
      if (muxClk) begin
        mStep++; slotClk++; nMclk++;
      end
      if (moveData) begin
        nRel++;
        check(slotClk == 32, "R10 release after 32 clocks", slotClk, 32);
      end
      if (recValid) begin
        int s, ed;
        s = mSlot;
        while (nextC < 64 && !keepF(s, nextC)) nextC++;
        ed = expData(s, nextC);
        nRec++;
        check(int'(recChan) == nextC, "R6 channel tag order", recChan, nextC);
        check(int'(recData) == ed, "R8/R9 record data", recData, ed);
        check(s < 4 && int'(recTime) == hitT[s] && int'(recBunch) == hitB[s] && recBoard == 8'hA5,
              "R7 record tags", recTime, (s < 4) ? hitT[s] : -1);
        check(busy, "R11 busy during records", busy, 1);
        nextC++;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic clearMon();
    mSlot = -1; mStep = -1; nextC = 0; slotClk = 0;
    nPln = 0; nPre = 0; drainPln = 0; nTrig = 0; nMrst = 0; nMclk = 0; nRel = 0; nRec = 0;
    inDrain = 0; seenBusy = 0; nHit = 0;
  endtask

  task automatic doHit(bit expectAccept);
    if (expectAccept) begin
      hitT[nHit] = tbCyc;
      hitB[nHit] = tbBunch;
      nHit++;
    end
    discHit = 1;
    cyc(1);
    discHit = 0;
    cyc(5);
  endtask

  task automatic startSpill();
    clearMon();
    spillOn = 1; tbBunch = 0;
    cyc(1);
    tickEn = 1;
    cyc(3);
  endtask

  task automatic endSpill();
    while (tbCyc % 4 != 2) cyc(1);
    spillOn = 0; inDrain = 1;
    cyc(1);
    check(busy, "R11 busy after spill end", busy, 1);
  endtask

  task automatic waitDone();
    while (busy) cyc(1);
    cyc(3);
    tickEn = 0;
    check(!busy, "R11 busy low at end", busy, 0);
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    #0.5;
    check({preReset, plnClk, skipTrig, muxReset, muxClk, adcSel, moveData, busy, recValid} == 0,
          "R1 reset outputs", {preReset, plnClk, skipTrig, muxReset, muxClk, adcSel, moveData, busy}, 0);
    cyc(2);

    // raw spill, five hits, latency 3
    rawMode = 1; latency = 8'd3;
    startSpill();
    for (int i = 0; i < 5; i++) doHit(i < 4);
    cyc(7);
    check(nPln > 0 && nPln == nPre, "R2 pipeline and preamp strobes", nPln, nPre);
    endSpill();
    waitDone();
    check(nTrig == 4, "R3 trigger limit", nTrig, 4);
    check(drainPln == 3, "R4 drain ticks", drainPln, 3);
    check(nMrst == 4, "R5 mux resets", nMrst, 4);
    check(nMclk == 128, "R5 mux clocks", nMclk, 128);
    check(nRel == 4, "R10 releases", nRel, 4);
    check(nRec == 256, "R8 raw record count", nRec, 256);

    // processed spill, hit during drain, latency 5
    rawMode = 0; threshold = 10'd20; latency = 8'd5;
    startSpill();
    doHit(1); doHit(1);
    endSpill();
    cyc(2);
    doHit(1);
    waitDone();
    check(nTrig == 3, "R4 hit accepted in drain", nTrig, 3);
    check(drainPln == 5, "R4 drain ticks processed", drainPln, 5);
    check(nRec == expRecs(3), "R9 processed record count", nRec, expRecs(3));

    // spill with no trigger
    rawMode = 1; threshold = 10'd0; latency = 8'd2;
    startSpill();
    cyc(10);
    endSpill();
    waitDone();
    check(nMrst == 0, "R11 no readout without trigger", nMrst, 0);
    check(seenBusy, "R11 busy during drain only", seenBusy, 1);
    check(drainPln == 2, "R4 drain ticks empty spill", drainPln, 2);

    // free-run, latency 0, hit during readout ignored
    clearMon();
    latency = 8'd0; freeRun = 1; tbBunch = 0;
    cyc(1);
    tickEn = 1;
    cyc(6);
    doHit(1);
    freeRun = 0;
    cyc(20);
    doHit(0);
    waitDone();
    check(nTrig == 1, "R12 one trigger in free-run", nTrig, 1);
    check(nMrst == 1, "R12 one slot read", nMrst, 1);
    check(nRec == 64, "R12 free-run records", nRec, 64);
    check(nTrig == 1, "R3 hit during readout ignored", nTrig, 1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule